// File: doc/BRIEF.md
# Dual-Range Dual-Modulus Prescaler

This block divides a fast input clock for a frequency-synthesis loop. It has two ranges. A range input picks the pair 16/17 or the pair 32/33. A modulus input then picks the lower or the higher ratio within that pair. A loop controller (a pulse swallow counter) drives the modulus input. The divided output goes back into that controller.

Both control inputs first pass through a two-flop synchroniser clocked by the input clock. The block reads them only at the clock edge on which the output rises. That reading fixes the ratio for the whole period which starts at that edge. Any activity on the controls between those edges has no effect on the period already running. The output comes straight from a register clocked by the input clock. Its edges therefore depend only on the input clock and never on when the controls arrive.

Every period starts with a high phase of half the base ratio. When the higher ratio is selected, the one extra input cycle always goes into the low phase.

Top module: `dual_modulus_prescaler`

## Requirements
- R1: While `rst_i` is high at a clock edge, `div_o` is high after that edge. The period restarts at that edge.
- R2: With `wide_i` low and `mod_i` high, the output period is 16 input cycles.
- R3: With `wide_i` low and `mod_i` low, the output period is 17 input cycles, with 9 of them low.
- R4: With `wide_i` high and `mod_i` high, the output period is 32 input cycles.
- R5: With `wide_i` high and `mod_i` low, the output period is 33 input cycles, with 17 of them low.
- R6: The high phase always lasts 8 input cycles when `wide_i` selects the low range (0) and 16 cycles when it selects the high range (1), whatever the modulus. Any extra cycle falls only in the low phase.
- R7: The ratio for a period starting at an output rising edge is set by the levels of `wide_i` and `mod_i` at the clock edge two edges before that rising edge. Changes at any other time leave that period unchanged.
- R8: The first period after reset is released uses the control levels held at the inputs during reset, following the same two-edge rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| wide_i | input | 1 | Range select: 0 gives 16/17, 1 gives 32/33 |
| mod_i | input | 1 | Modulus: 1 gives the lower ratio, 0 gives the higher ratio |
| div_o | output | 1 | Divided output, registered on the input clock |

## Verification
Two functions can fall on the same clock edge. On one edge the counter wraps and the output rises. On that same edge, the synchroniser output may be delivering a freshly changed control level. That control level is sampled on that same edge.

The bench provokes this collision. It toggles `mod_i` and, less often, `wide_i` at random on individual cycles, so that changes land on every offset around the wrap. Each measured period and high phase is judged against a bench model. That model takes the control levels from exactly two edges before each observed rising edge. A change that lands one edge early or one edge late therefore shows up as a wrong period length.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;

    // half period of the low range; the high range doubles it
    localparam int HALF_LO = 8;
    localparam int HALF_HI = 2 * HALF_LO;
    // counter must hold the longest period minus one
    localparam int CNT_W   = $clog2(2 * HALF_HI + 2);
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic wide;   // 1: high range
        logic extra;  // 1: one extra cycle in the low phase
    } mode_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        mode_t            mode;
        logic             out;
    } core_t;

endpackage

// File: rtl/prescaler_sync.sv
module prescaler_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk_i) begin
        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/prescaler_core.sv
module prescaler_core
    import prescaler_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic wide_s_i,
    input  logic mod_s_i,
    output logic div_o
);

    core_t            cur_q, nxt_d;
    logic [CNT_W-1:0] half_w;
    logic [CNT_W-1:0] last_w;
    mode_t            sampled_w;

    always_comb begin
        half_w          = cur_q.mode.wide ? CNT_W'(HALF_HI) : CNT_W'(HALF_LO);
        last_w          = CNT_W'(2 * int'(half_w) + int'(cur_q.mode.extra) - 1);
        sampled_w.wide  = wide_s_i;
        sampled_w.extra = ~mod_s_i;

        nxt_d = cur_q;
        if (rst_i) begin
            nxt_d.cnt  = '0;
            nxt_d.mode = sampled_w;
            nxt_d.out  = 1'b1;
        end else if (cur_q.cnt == last_w) begin
            nxt_d.cnt  = '0;
            nxt_d.mode = sampled_w;
            nxt_d.out  = 1'b1;
        end else begin
            nxt_d.cnt  = cur_q.cnt + CNT_W'(1);
            nxt_d.out  = (nxt_d.cnt < half_w);
        end
    end

    always_ff @(posedge clk_i) begin
        cur_q <= nxt_d;
    end

    assign div_o = cur_q.out;

    // R1: one edge after reset is seen, the output is high
    p_reset_high_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> cur_q.out)
        else $error("p_reset_high_r1");

    // R6: the high phase ends exactly at half the base ratio
    p_fall_at_half_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(cur_q.out) |-> (cur_q.cnt == half_w))
        else $error("p_fall_at_half_r6");

    // R7: a rising output marks the start of a new count
    p_rise_at_wrap_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cur_q.out) |-> (cur_q.cnt == '0))
        else $error("p_rise_at_wrap_r7");

    // R7: the mode cannot change except at a rising edge of the output
    p_mode_held_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$rose(cur_q.out)) |-> $stable(cur_q.mode))
        else $error("p_mode_held_r7");

    // R5: the counter never passes the longest period
    p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        cur_q.cnt <= CNT_W'(2 * HALF_HI))
        else $error("p_cnt_bound_r5");

endmodule

// File: rtl/dual_modulus_prescaler.sv
module dual_modulus_prescaler
    import prescaler_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic wide_i,
    input  logic mod_i,
    output logic div_o
);

    logic [1:0] ctrl_s;

    prescaler_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i   (clk_i),
        .async_i ({wide_i, mod_i}),
        .sync_o  (ctrl_s)
    );

    prescaler_core i_core (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wide_s_i (ctrl_s[1]),
        .mod_s_i  (ctrl_s[0]),
        .div_o    (div_o)
    );

endmodule

// File: tb/test_dual_modulus_prescaler.sv
module test_dual_modulus_prescaler;

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic wide_i = 1'b0;
    logic mod_i = 1'b1;
    logic div_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_modulus_prescaler i_dual_modulus_prescaler (
        .clk_i  (clk),
        .rst_i  (rst_i),
        .wide_i (wide_i),
        .mod_i  (mod_i),
        .div_o  (div_o)
    );

    // history of inputs seen at the last three edges, index 0 newest
    bit w_h0, w_h1, w_h2, m_h0, m_h1, m_h2;
    bit prev_d;
    int per_cnt, hi_cnt, exp_p, exp_h;
    bit first_per, toggled;

    function automatic int exp_half(bit w);
        return w ? 16 : 8;
    endfunction

    function automatic int exp_period(bit w, bit m);
        return 2 * exp_half(w) + (m ? 0 : 1);
    endfunction

    function automatic string mode_tag(bit w, bit m);
        if (!w && m)  return "R2";
        if (!w && !m) return "R3";
        if (w && m)   return "R4";
        return "R5";
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic start_period();
        exp_h   = exp_half(w_h2);
        exp_p   = exp_period(w_h2, m_h2);
        per_cnt = 1;
        hi_cnt  = 1;
        toggled = 1'b0;
    endtask

    // one clock: observe the edge just passed, then drive the next inputs
    task automatic step(bit nrst, bit nw, bit nm);
        bit d;
        bit rst_at_edge;
        @(negedge clk);
        d = div_o;
        rst_at_edge = rst_i;
        w_h2 = w_h1; w_h1 = w_h0; w_h0 = wide_i;
        m_h2 = m_h1; m_h1 = m_h0; m_h0 = mod_i;
        if (rst_at_edge) begin
            chk(d == 1'b1, "R1", d, 1);
            start_period();
            first_per = 1'b1;
        end else if (d && !prev_d) begin
            chk(per_cnt == exp_p, mode_tag(exp_h == 16, exp_p[0] == 1'b0), per_cnt, exp_p);
            chk(hi_cnt == exp_h, "R6", hi_cnt, exp_h);
            if (toggled) chk(per_cnt == exp_p, "R7", per_cnt, exp_p);
            if (first_per) chk(per_cnt == exp_p, "R8", per_cnt, exp_p);
            first_per = 1'b0;
            start_period();
        end else begin
            per_cnt++;
            if (d) hi_cnt++;
        end
        prev_d = d;
        if (nm != mod_i || nw != wide_i) toggled = 1'b1;
        rst_i  = nrst;
        wide_i = nw;
        mod_i  = nm;
    endtask

    task automatic do_reset(bit w, bit m, int n);
        for (int i = 0; i < n; i++) step(1'b1, w, m);
        step(1'b0, w, m);
    endtask

    initial begin
        void'($urandom(32'd20250));
        prev_d = 1'b1;
        first_per = 1'b0;
        // reset with the low range, lower ratio held
        rst_i = 1'b1; wide_i = 1'b0; mod_i = 1'b1;
        do_reset(1'b0, 1'b1, 5);
        // directed: each mode held static for several periods
        for (int i = 0; i < 100; i++) step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 110; i++) step(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 200; i++) step(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 200; i++) step(1'b0, 1'b1, 1'b0);
        // reset in the high range, higher ratio (R8)
        do_reset(1'b1, 1'b0, 4);
        for (int i = 0; i < 100; i++) step(1'b0, 1'b1, 1'b0);
        // reset landing in the middle of a period (R1)
        for (int i = 0; i < 7; i++) step(1'b0, 1'b0, 1'b1);
        do_reset(1'b0, 1'b0, 3);
        for (int i = 0; i < 60; i++) step(1'b0, 1'b0, 1'b0);
        // random: modulus toggled often, range rarely
        for (int i = 0; i < 6000; i++) begin
            bit nw = wide_i;
            bit nm = mod_i;
            if (($urandom % 6) == 0)   nm = ~nm;
            if (($urandom % 150) == 0) nw = ~nw;
            step(1'b0, nw, nm);
        end
        // single-cycle glitches on the modulus
        for (int i = 0; i < 400; i++) begin
            step(1'b0, 1'b0, (($urandom % 20) == 0) ? 1'b0 : 1'b1);
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule